// File: doc/BRIEF.md
# Cubic spline DC-bias generator

This block drives one output channel with a piecewise-cubic voltage. It produces a new 16-bit two's-complement DAC code on every clock, at one sample per 8 ns at 125 MHz. A host loads the segment's coefficients as nine 16-bit words. The block assembles them into a pending set of four fields. The waveform in progress keeps running from its own accumulators until a trigger pulse copies the whole pending set into them in a single cycle.

After the trigger, the block advances the cubic by forward differences: three 48-bit adders form a cascade, and the top 16 bits of the position accumulator are the output sample. The coefficient words are already the forward differences of the polynomial over one 8 ns step. The block therefore only accumulates and does no multiplication. Several channels triggered by the same pulse change segment on the same clock edge.

Top module: `cubic_bias_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no trigger, sample_o is 0 and every accumulator and pending word is zero.
- R2: A word written with wr_en_i and no trigger changes only the pending set. sample_o keeps following the running waveform.
- R3: When trig_i is sampled high at a clock edge, sample_o after that edge equals pending word 0.
- R4: On each edge without a trigger, the accumulators update from their values before the edge: position += velocity, velocity += curvature, curvature += jerk. Jerk stays constant.
- R5: Word layout by wr_addr_i: 0 is a0; 1 and 2 are a1 low then high; 3, 4 and 5 are a2 from least to most significant; 6, 7 and 8 are a3 from least to most significant. On a trigger, position is loaded with {a0, 32 zero bits}, velocity with {a1, 16 zero bits}, curvature with a2 and jerk with a3, all 48 bits wide. sample_o is position bits 47:32.
- R6: A write and a trigger in the same cycle load the accumulators from the pending value held before the write. The written word stays pending for the next trigger.
- R7: With velocity, curvature and jerk all zero, sample_o holds its value indefinitely.
- R8: Every accumulator wraps modulo 2^48 without saturation. For example, 0xFFFF in the top word with a velocity of 2^32 steps to 0x0000.
- R9: Writes with wr_addr_i from 9 to 15 change nothing.
- R10: The pending set is kept after a trigger. A second trigger with no writes in between restarts the same segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one output step per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Coefficient word write strobe |
| wr_addr_i | input | 4 | Coefficient word index |
| wr_data_i | input | 16 | Coefficient word value |
| trig_i | input | 1 | Commit the pending set to the accumulators |
| sample_o | output | 16 | Output DAC code, two's complement |

## Verification
The assertions assume that trig_i and wr_en_i are single-cycle, level-sampled strobes. They also assume that wr_addr_i and wr_data_i are settled whenever wr_en_i is high. The bench meets this by changing every input only on the falling clock edge. It also places writes and triggers in separate cycles, except for the deliberate same-cycle case of R6. The random coefficient rounds use arbitrary 16-bit words. Wrap-around (R8) therefore happens often, and the reference model has to reproduce it.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int WORD_W  = 16;
  localparam int N_WORDS = 9;
  localparam int N_STAGE = 4;
  localparam int ADDR_W  = 4;
  localparam int ACC_W   = 3 * WORD_W;

  typedef logic [WORD_W-1:0]              word_t;
  typedef logic [ACC_W-1:0]               acc_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] bank_t;
endpackage

// File: rtl/cbg_shadow.sv
module cbg_shadow
  import cbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  word_t             wr_data_i,
  output bank_t             bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (wr_addr_i == ADDR_W'(i)) bank_o[i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/cbg_unpack.sv
module cbg_unpack
  import cbg_pkg::*;
(
  input  bank_t bank_i,
  output acc_t  pos_o,
  output acc_t  vel_o,
  output acc_t  crv_o,
  output acc_t  jrk_o
);
  // fractional alignment: upper bits of every field line up with a0
  assign pos_o = {bank_i[0], {(2*WORD_W){1'b0}}};
  assign vel_o = {bank_i[2], bank_i[1], {WORD_W{1'b0}}};
  assign crv_o = {bank_i[5], bank_i[4], bank_i[3]};
  assign jrk_o = {bank_i[8], bank_i[7], bank_i[6]};
endmodule

// File: rtl/cbg_stage.sv
module cbg_stage #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= init_i;
    else             q_o <= q_o + step_i;
  end
endmodule

// File: rtl/cubic_bias_gen.sv
module cubic_bias_gen
  import cbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              trig_i,
  output logic [WORD_W-1:0] sample_o
);
  bank_t pend_q;
  acc_t  init_v [N_STAGE];
  acc_t  acc_q  [N_STAGE];
  acc_t  pos_init, vel_init, crv_init, jrk_init;
  acc_t  pos_q, vel_q, crv_q, jrk_q;

  cbg_shadow u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .bank_o    (pend_q)
  );

  cbg_unpack u_unpack (
    .bank_i (pend_q),
    .pos_o  (pos_init),
    .vel_o  (vel_init),
    .crv_o  (crv_init),
    .jrk_o  (jrk_init)
  );

  assign init_v[0] = pos_init;
  assign init_v[1] = vel_init;
  assign init_v[2] = crv_init;
  assign init_v[3] = jrk_init;

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    acc_t step;
    if (s == N_STAGE - 1) begin : g_last
      assign step = '0;
    end else begin : g_mid
      assign step = acc_q[s+1];
    end
    cbg_stage #(.W(ACC_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (trig_i),
      .init_i (init_v[s]),
      .step_i (step),
      .q_o    (acc_q[s])
    );
  end

  assign pos_q = acc_q[0];
  assign vel_q = acc_q[1];
  assign crv_q = acc_q[2];
  assign jrk_q = acc_q[3];

  assign sample_o = pos_q[ACC_W-1 -: WORD_W];
endmodule

// File: rtl/cbg_checker.sv
module cbg_checker
  import cbg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              trig_i,
  input logic [WORD_W-1:0] sample_o,
  input bank_t             pend_i,
  input acc_t              pos_i,
  input acc_t              vel_i,
  input acc_t              crv_i,
  input acc_t              jrk_i
);
  a_r3_trig_loads_a0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> sample_o == $past(pend_i[0]));

  a_r6_old_word_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && wr_en_i && wr_addr_i == '0)
      |=> (sample_o == $past(pend_i[0])) && (pend_i[0] == $past(wr_data_i)));

  a_r9_high_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= ADDR_W'(N_WORDS)) |=> $stable(pend_i));

  a_r10_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pend_i));

  a_r7_flat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && vel_i == '0 && crv_i == '0 && jrk_i == '0)
      |=> $stable(sample_o) && $stable(pos_i));

  a_r4_jerk_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> $stable(jrk_i));

  a_r2_write_keeps_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !trig_i && vel_i == '0 && crv_i == '0 && jrk_i == '0)
      |=> $stable(sample_o));
endmodule

bind cubic_bias_gen cbg_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .trig_i    (trig_i),
  .sample_o  (sample_o),
  .pend_i    (pend_q),
  .pos_i     (pos_q),
  .vel_i     (vel_q),
  .crv_i     (crv_q),
  .jrk_i     (jrk_q)
);

// File: tb/cubic_bias_gen_test.sv
module cubic_bias_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        trig_i = 1'b0;
  logic [15:0] sample_o;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit [47:0] m_acc [4];
  bit [15:0] m_pend [9];

  cubic_bias_gen uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .trig_i    (trig_i),
    .sample_o  (sample_o)
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_acc[i]) m_acc[i] = '0;
      foreach (m_pend[i]) m_pend[i] = '0;
    end else begin
      if (trig_i) begin
        m_acc[0] = {m_pend[0], 32'h0};
        m_acc[1] = {m_pend[2], m_pend[1], 16'h0};
        m_acc[2] = {m_pend[5], m_pend[4], m_pend[3]};
        m_acc[3] = {m_pend[8], m_pend[7], m_pend[6]};
      end else begin
        bit [47:0] p, v, c;
        p = m_acc[0] + m_acc[1];
        v = m_acc[1] + m_acc[2];
        c = m_acc[2] + m_acc[3];
        m_acc[0] = p;
        m_acc[1] = v;
        m_acc[2] = c;
      end
      if (wr_en_i && wr_addr_i < 4'd9) m_pend[wr_addr_i] = wr_data_i;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sample_o act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R4 and others: per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) chk(cur_req, sample_o, m_acc[0][47:32]);
  end

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic trig();
    trig_i = 1'b1;
    cyc();
    trig_i = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R1", sample_o, 16'h0000);
    rst_ni = 1'b1;
    cyc();
    chk("R1", sample_o, 16'h0000);

    cur_req = "R2";
    wr(4'd0, 16'h5555);
    wr(4'd2, 16'h0001);
    repeat (3) cyc();
    chk("R2", sample_o, 16'h0000);

    cur_req = "R3";
    trig();
    chk("R3", sample_o, 16'h5555);
    cur_req = "R5";
    repeat (4) cyc();
    chk("R5", sample_o, 16'h5559);

    cur_req = "R8";
    wr(4'd0, 16'hFFFE);
    trig();
    chk("R8", sample_o, 16'hFFFE);
    cyc();
    cyc();
    chk("R8", sample_o, 16'h0000);

    cur_req = "R10";
    repeat (5) cyc();
    trig();
    chk("R10", sample_o, 16'hFFFE);

    cur_req = "R6";
    wr(4'd2, 16'h0000);
    wr(4'd0, 16'h1111);
    trig();
    trig_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 16'h2222;
    cyc();
    trig_i = 1'b0; wr_en_i = 1'b0;
    chk("R6", sample_o, 16'h1111);
    cur_req = "R7";
    repeat (50) cyc();
    chk("R7", sample_o, 16'h1111);
    cur_req = "R6";
    trig();
    chk("R6", sample_o, 16'h2222);

    cur_req = "R9";
    wr(4'd9, 16'hAAAA);
    wr(4'd15, 16'hBBBB);
    trig();
    chk("R9", sample_o, 16'h2222);
    repeat (10) cyc();
    chk("R9", sample_o, 16'h2222);

    cur_req = "R4";
    for (int w = 0; w < 9; w++) wr(w[3:0], (w == 8) ? 16'h0001 : 16'h0000);
    trig();
    repeat (5) cyc();
    chk("R4", sample_o, 16'd10);

    for (int r = 0; r < 6; r++) begin
      for (int w = 0; w < 9; w++) wr(w[3:0], 16'($urandom));
      trig();
      repeat (300) cyc();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule